// File: doc/BRIEF.md
# Pipelined Flash Program/Erase Sequencer

This block drives two flash arrays: a program array and a smaller data array. It takes word-program and page-erase requests from a CPU-side request port and runs them one at a time. In front of the execution stage sits a one-entry holding register. Software can therefore load the next request while the current one is still running. It only needs to watch the `full` flag to know when a new request may go in. The arrays are behavioural: erasing a page forces every bit in it to 1, and programming a word can only clear bits.

Each operation takes a fixed number of cycles, set by parameters. Protection is decided outside the block and arrives as a grant input. A read port serves byte and word reads from either array. A read stalls while the array it targets cannot be read. A program-array read waits while a program-array operation is pending. A data-array read waits while any operation is pending.

Top module: `flash_seq`

## Requirements
- R1: After reset `busy`, `full` and `dropped` are 0, and every word of both arrays reads 0xFFFF.
- R2: A program request with `req_erase`=0 replaces the addressed word with the old word AND `req_data`. The new value is in the array T_PROG+1 clock edges after the edge that accepted the request, provided the execution stage was idle.
- R3: A request accepted while `full`=0 sets `full` on the next edge. `full` clears on the edge where the held request moves into the execution stage. A request may be accepted while an earlier one is still executing.
- R4: A granted request presented while `full`=1 is discarded and leaves the arrays untouched. It sets `dropped`, which stays at 1 until reset.
- R5: An erase request with `req_erase`=1 sets every word of the addressed page to 0xFFFF and leaves other pages unchanged. A page is PROG_PAGE words in the program array (`req_dsel`=0) and DATA_PAGE words in the data array (`req_dsel`=1). The page is selected by the word address divided by the page size.
- R6: A granted erase request presented while `busy`=1 is rejected. The array is left unchanged and `dropped` is set.
- R7: `busy` rises on the edge that accepts a request and stays high without a gap until the last queued operation completes. A lone program keeps it high for T_PROG+1 cycles and a lone erase for T_ERASE+1 cycles. Two back-to-back programs, the second accepted as soon as `full` clears, keep it high for 2*T_PROG+1 cycles.
- R8: `rd_stall` is high when `rd_en` is set and the target array is busy. A program-array read (`rd_dsel`=0) stalls only while a program-array operation is held or executing. A data-array read (`rd_dsel`=1) stalls while any operation is held or executing. A stalled read produces no `rd_valid`.
- R9: A read that does not stall returns `rd_valid`=1 and `rd_data` one edge later. `rd_addr` is a byte address and bits above bit 0 select the word. With `rd_byte`=0 the whole word is returned. With `rd_byte`=1 the byte is returned zero-extended: the low byte when `rd_addr[0]`=0, the high byte when it is 1.
- R10: A request with `req_grant`=0 is ignored. `full` and `busy` stay 0 and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_erase | input | 1 | 1 = page erase, 0 = word program |
| req_dsel | input | 1 | 0 = program array, 1 = data array |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Program data |
| req_grant | input | 1 | Protection grant for this request |
| rd_en | input | 1 | Read request |
| rd_dsel | input | 1 | Read target array |
| rd_addr | input | AW+1 | Byte address of the read |
| rd_byte | input | 1 | 1 = byte read, 0 = word read |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | Read data valid |
| rd_stall | output | 1 | Read cannot be served this cycle |
| full | output | 1 | Holding register occupied |
| busy | output | 1 | Operation held or executing |
| dropped | output | 1 | Sticky: a request was discarded |

## Verification
`full` follows an accepted request by one edge. Read data follows an accepted read by one edge. `rd_stall` is combinational and is checked in the same cycle as the read it applies to. A program or erase reaches the array T_PROG+1 or T_ERASE+1 edges after acceptance. The bench does not guess that edge. It counts the falling-edge samples during which `busy` is high and compares the count with those figures, then reads the array back once `busy` is low. Every input is driven and every output sampled at the falling edge. The sweeps program every word of both arrays twice, erase one page in each array, and read every word and byte back against a model updated arithmetically.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int DW      = 16,
  parameter int PWORDS  = 64,
  parameter int DWORDS  = 32,
  parameter int PROG_PAGE = 16,
  parameter int DATA_PAGE = 8,
  parameter int T_PROG  = 3,
  parameter int T_ERASE = 6,
  parameter int AW      = $clog2(PWORDS > DWORDS ? PWORDS : DWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_erase,
  input  logic          req_dsel,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_grant,
  input  logic          rd_en,
  input  logic          rd_dsel,
  input  logic [AW:0]   rd_addr,
  input  logic          rd_byte,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_stall,
  output logic          full,
  output logic          busy,
  output logic          dropped
);
  localparam int PAW  = $clog2(PWORDS);
  localparam int DAW  = $clog2(DWORDS);
  localparam int TMAX = T_ERASE > T_PROG ? T_ERASE : T_PROG;
  localparam int CW   = $clog2(TMAX) + 1;
  localparam int HB   = DW / 2;

  logic [DW-1:0] pmem [PWORDS];
  logic [DW-1:0] dmem [DWORDS];

  logic          h_erase, h_dsel;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;

  logic          x_act, x_erase, x_dsel;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_data;
  logic [CW-1:0] x_cnt;

  logic x_done, xfer, accept, reject, busy_p, busy_d;
  logic [DW-1:0] rword;

  assign x_done = x_act && (x_cnt == '0);
  assign xfer   = full && (!x_act || x_done);
  assign busy_p = (full && !h_dsel) || (x_act && !x_dsel);
  assign busy_d = (full && h_dsel) || (x_act && x_dsel);
  assign busy   = full || x_act;
  assign accept = req_valid && req_grant && !full && !(req_erase && busy);
  assign reject = req_valid && req_grant && !accept;

  assign rd_stall = rd_en && (rd_dsel ? (busy_p || busy_d) : busy_p);
  assign rword    = rd_dsel ? dmem[rd_addr[DAW:1]] : pmem[rd_addr[PAW:1]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      dropped <= 1'b0;
      h_erase <= 1'b0;
      h_dsel  <= 1'b0;
      h_addr  <= '0;
      h_data  <= '0;
    end else begin
      if (reject) dropped <= 1'b1;
      if (accept) begin
        full    <= 1'b1;
        h_erase <= req_erase;
        h_dsel  <= req_dsel;
        h_addr  <= req_addr;
        h_data  <= req_data;
      end else if (xfer) begin
        full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_act   <= 1'b0;
      x_erase <= 1'b0;
      x_dsel  <= 1'b0;
      x_addr  <= '0;
      x_data  <= '0;
      x_cnt   <= '0;
    end else if (xfer) begin
      x_act   <= 1'b1;
      x_erase <= h_erase;
      x_dsel  <= h_dsel;
      x_addr  <= h_addr;
      x_data  <= h_data;
      x_cnt   <= h_erase ? CW'(T_ERASE - 1) : CW'(T_PROG - 1);
    end else if (x_done) begin
      x_act <= 1'b0;
    end else if (x_act) begin
      x_cnt <= x_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PWORDS; i++) pmem[i] <= '1;
      for (int i = 0; i < DWORDS; i++) dmem[i] <= '1;
    end else if (x_done) begin
      if (!x_dsel) begin
        if (x_erase) begin
          for (int i = 0; i < PWORDS; i++)
            if (i / PROG_PAGE == int'(x_addr[PAW-1:0]) / PROG_PAGE) pmem[i] <= '1;
        end else begin
          pmem[x_addr[PAW-1:0]] <= pmem[x_addr[PAW-1:0]] & x_data;
        end
      end else begin
        if (x_erase) begin
          for (int i = 0; i < DWORDS; i++)
            if (i / DATA_PAGE == int'(x_addr[DAW-1:0]) / DATA_PAGE) dmem[i] <= '1;
        end else begin
          dmem[x_addr[DAW-1:0]] <= dmem[x_addr[DAW-1:0]] & x_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en && !rd_stall;
      if (rd_en && !rd_stall)
        rd_data <= rd_byte ? {{(DW-HB){1'b0}}, rd_addr[0] ? rword[DW-1:HB] : rword[HB-1:0]}
                           : rword;
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_grant,
  input logic req_erase,
  input logic full,
  input logic busy,
  input logic dropped,
  input logic rd_en,
  input logic rd_stall,
  input logic rd_valid,
  input logic x_act
);
  p_accept_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_grant && !full && !(req_erase && busy) |=> full);

  p_full_moves_to_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> x_act);

  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_grant && full |=> dropped);

  p_drop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> dropped);

  p_erase_busy_rejected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_grant && req_erase && busy |=> dropped);

  p_busy_after_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> busy);

  p_stall_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_stall |=> !rd_valid);

  p_ungranted_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_grant && !busy |=> !busy);
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grant(req_grant),
  .req_erase(req_erase), .full(full), .busy(busy), .dropped(dropped),
  .rd_en(rd_en), .rd_stall(rd_stall), .rd_valid(rd_valid), .x_act(x_act)
);

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int PW = 64, DWD = 32, PP = 16, DP = 8, TP = 3, TE = 6, AW = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_erase = 0, req_dsel = 0, req_grant = 1;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic rd_en = 0, rd_dsel = 0, rd_byte = 0;
  logic [AW:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic rd_valid, rd_stall, full, busy, dropped;

  logic [15:0] pm [PW];
  logic [15:0] dm [DWD];
  int checks = 0, fails = 0;

  flash_seq dut (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < PW; i++) pm[i] = 16'hFFFF;
    for (int i = 0; i < DWD; i++) dm[i] = 16'hFFFF;
    @(negedge clk);
  endtask

  task automatic send(bit er, bit ds, int a, logic [15:0] d, bit g);
    req_valid = 1; req_erase = er; req_dsel = ds;
    req_addr = AW'(a); req_data = d; req_grant = g;
    @(negedge clk);
    req_valid = 0; req_grant = 1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic model_prog(bit ds, int a, logic [15:0] d);
    if (ds) dm[a] = dm[a] & d; else pm[a] = pm[a] & d;
  endtask

  task automatic model_erase(bit ds, int a);
    if (ds) begin
      for (int i = 0; i < DWD; i++) if (i / DP == a / DP) dm[i] = 16'hFFFF;
    end else begin
      for (int i = 0; i < PW; i++) if (i / PP == a / PP) pm[i] = 16'hFFFF;
    end
  endtask

  task automatic prog(bit ds, int a, logic [15:0] d);
    while (full) @(negedge clk);
    send(0, ds, a, d, 1);
    model_prog(ds, a, d);
  endtask

  task automatic erase(bit ds, int a);
    wait_idle();
    send(1, ds, a, 16'h0, 1);
    model_erase(ds, a);
  endtask

  task automatic rd(bit ds, int baddr, bit byt, string req);
    logic [15:0] w, e;
    w = ds ? dm[baddr / 2] : pm[baddr / 2];
    e = !byt ? w : (baddr % 2 == 1) ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    rd_en = 1; rd_dsel = ds; rd_addr = (AW+1)'(baddr); rd_byte = byt;
    #1 chk(!rd_stall, req, {15'h0, rd_stall}, 16'h0);
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid, req, {15'h0, rd_valid}, 16'h1);
    chk(rd_data == e, req, rd_data, e);
  endtask

  task automatic verify_all(string req);
    wait_idle();
    for (int i = 0; i < PW; i++) rd(0, 2 * i, 0, req);
    for (int i = 0; i < DWD; i++) rd(1, 2 * i, 0, req);
  endtask

  function automatic logic [15:0] pat(int i, int k);
    return 16'((i * 16'h02B5 + k * 16'h9E37) ^ 16'h5A3C);
  endfunction

  initial begin
    int n;
    do_reset();
    chk(!busy && !full && !dropped, "R1", {13'h0, busy, full, dropped}, 16'h0);
    verify_all("R1");

    // R2/R7: lone program timing
    send(0, 1, 3, 16'h1234, 1); model_prog(1, 3, 16'h1234);
    chk(full, "R3", {15'h0, full}, 16'h1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == TP + 1, "R7", 16'(n), 16'(TP + 1));
    rd(1, 6, 0, "R2");

    // R5/R7: lone erase timing
    send(1, 0, 5, 16'h0, 1); model_erase(0, 5);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == TE + 1, "R7", 16'(n), 16'(TE + 1));

    // R3/R7: back-to-back programs
    send(0, 0, 5, 16'hF0F0, 1); model_prog(0, 5, 16'hF0F0);
    @(negedge clk);
    chk(!full && busy, "R3", {14'h0, full, busy}, 16'h1);
    send(0, 0, 6, 16'h0F0F, 1); model_prog(0, 6, 16'h0F0F);
    chk(full, "R3", {15'h0, full}, 16'h1);
    n = 2;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 2 * TP + 1, "R7", 16'(n), 16'(2 * TP + 1));
    rd(0, 10, 0, "R2"); rd(0, 12, 0, "R2");

    // R4: request while full is dropped
    send(0, 1, 7, 16'h00FF, 1); model_prog(1, 7, 16'h00FF);
    send(0, 1, 8, 16'h0000, 1);
    chk(dropped, "R4", {15'h0, dropped}, 16'h1);
    wait_idle();
    rd(1, 16, 0, "R4"); rd(1, 14, 0, "R4");
    chk(dropped, "R4", {15'h0, dropped}, 16'h1);

    do_reset();
    chk(!dropped, "R1", {15'h0, dropped}, 16'h0);

    // R6: erase while busy rejected
    send(0, 0, 40, 16'h0000, 1); model_prog(0, 40, 16'h0000);
    @(negedge clk);
    send(1, 0, 33, 16'h0, 1);
    chk(dropped, "R6", {15'h0, dropped}, 16'h1);
    wait_idle();
    rd(0, 80, 0, "R6");

    // R10: ungranted request ignored
    send(0, 1, 1, 16'h0000, 0);
    chk(!full && !busy, "R10", {14'h0, full, busy}, 16'h0);
    rd(1, 2, 0, "R10");

    // R8: stall rules
    send(0, 1, 2, 16'h5555, 1); model_prog(1, 2, 16'h5555);
    rd_en = 1; rd_dsel = 0; rd_addr = '0; rd_byte = 0;
    #1 chk(!rd_stall, "R8", {15'h0, rd_stall}, 16'h0);
    rd_dsel = 1;
    #1 chk(rd_stall, "R8", {15'h0, rd_stall}, 16'h1);
    @(negedge clk);
    chk(!rd_valid, "R8", {15'h0, rd_valid}, 16'h0);
    rd_en = 0;
    wait_idle();
    send(0, 0, 9, 16'hAAAA, 1); model_prog(0, 9, 16'hAAAA);
    rd_en = 1; rd_dsel = 0;
    #1 chk(rd_stall, "R8", {15'h0, rd_stall}, 16'h1);
    rd_dsel = 1;
    #1 chk(rd_stall, "R8", {15'h0, rd_stall}, 16'h1);
    rd_en = 0;
    wait_idle();
    rd(0, 18, 0, "R8"); rd(1, 4, 0, "R8");

    // Sweeps: R2 program AND over all words, R5 page erase, R9 byte reads
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < PW; i++) prog(0, i, pat(i, k));
      for (int i = 0; i < DWD; i++) prog(1, i, pat(i + 100, k));
    end
    verify_all("R2");
    erase(1, 9);
    erase(0, 20);
    verify_all("R5");
    for (int b = 0; b < 2 * DWD; b++) rd(1, b, 1, "R9");
    for (int b = 0; b < 2 * PW; b++) rd(0, b, 1, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule